// File: doc/BRIEF.md
# Backplane Slave Read Interface

This block is the slave side of an asynchronous, strobe-handshaked backplane data bus. The bus carries no clock. The master puts an address and a 6-bit modifier code on the bus and lowers the address strobe. It then lowers the data strobes one beat at a time. Each beat waits for a data-acknowledge or a bus-error reply. The block brings the strobes and the write line into its local clock domain through two-flop synchronizers. It decodes the modifier into an address width and a transfer kind, and compares the upper address bits with a configured base address to decide whether the cycle is meant for this board.

Every read that selects this board takes words from a local event FIFO, which the front-end logic fills through a push port. A read cannot be repeated: each accepted beat removes the words it returns. Single-cycle modes return one word per address cycle. Block modes return one word per beat, up to a fixed burst limit. The 64-bit multiplexed block mode returns two FIFO words per beat. The first word goes out on the lines that carried the address, and the second on the data lines. Reads that cannot be served are answered with a bus error and leave the FIFO as it was. This covers an empty FIFO, a write, an unknown modifier, and a beat past the limit.

Top module: `bpl_slave_if`

## Requirements
- R1: During and after reset, bus_ack_n and bus_err_n are high, data_oe is low and evt_full is low (FIFO empty).
- R2: Accepted modifier codes: 0x39 (24-bit single) and 0x3B (24-bit block) compare address bits [23:WIN_BITS] with cfg_base. 0x29 (16-bit single) compares bits [15:WIN_BITS]. 0x09 (32-bit single), 0x0B (32-bit block) and 0x08 (32-bit multiplexed 64-bit block) compare bits [31:WIN_BITS]. The low WIN_BITS bits are ignored.
- R3: A cycle whose compared address bits differ from cfg_base gets no reply: bus_ack_n and bus_err_n stay high, and the FIFO is not touched.
- R4: A selected single or block read beat removes the oldest FIFO word and presents it on beat_lo, with beat_hi at zero, in first-in first-out order.
- R5: bus_ack_n falls only after data_oe has been high and beat_lo unchanged for at least one local clock. It stays low until both data strobes are high again.
- R6: A selected read beat that finds too few words in the FIFO gets bus_err_n low instead of an acknowledge, and removes nothing.
- R7: A modifier code outside the accepted set whose bits [31:WIN_BITS] match cfg_base gets a bus error. So does a write (bus_wr_n low at the address strobe) to a selected address.
- R8: In the single-cycle modes (0x39, 0x29, 0x09), a second data beat within the same address strobe gets a bus error and removes nothing.
- R9: In the block modes, successive beats remove successive words. At most MAX_WORDS (256) words are delivered per address strobe, and the beat after that gets a bus error.
- R10: In mode 0x08, each beat removes two words: the first on beat_hi, the second on beat_lo. With fewer than two words stored, the beat gets a bus error.
- R11: A push while the FIFO holds FIFO_DEPTH words is dropped, and evt_full is high while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Board base address, compared above WIN_BITS |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 2 | Data strobes, active low |
| bus_wr_n | input | 1 | Write line, low means write |
| bus_amod | input | 6 | Address modifier code |
| bus_addr | input | 32 | Address lines |
| bus_ack_n | output | 1 | Data acknowledge, active low |
| bus_err_n | output | 1 | Bus error, active low |
| data_oe | output | 1 | Read data valid, enables the bus drivers |
| beat_hi | output | 32 | Upper beat word (driven onto the address lines in mode 0x08) |
| beat_lo | output | 32 | Lower beat word (driven onto the data lines) |
| evt_push | input | 1 | Push one word into the event FIFO |
| evt_word | input | 32 | Word to push |
| evt_full | output | 1 | Event FIFO full |

## Verification
Some properties are checked on every cycle. Data must be valid and unchanged for a clock before the acknowledge falls, and the acknowledge must stay low until the strobes are released. A single-cycle mode must never count more than one word, and the burst word count must never exceed its cap. Multiplexed beats must always remove words in pairs. The FIFO must never be popped while empty or filled past its depth. Other behaviour shows only in the bench's scenarios. That covers which modifier and address combinations select the board and which stay silent, the order of the returned words, and the error replies for writes, empty reads and over-long bursts.

// File: rtl/bpl_slave_pkg.sv
package bpl_slave_pkg;

    // Kind of transfer selected by the modifier code
    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_SINGLE = 2'd1,
        XF_BLOCK  = 2'd2,
        XF_MBLT   = 2'd3
    } xfer_e;

    // Handshake state machine
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SKIP = 3'd1,
        ST_SEL  = 3'd2,
        ST_POPA = 3'd3,
        ST_POPB = 3'd4,
        ST_HOLD = 3'd5,
        ST_ACK  = 3'd6,
        ST_ERR  = 3'd7
    } st_e;

    localparam int BUS_W = 32;

endpackage

// File: rtl/bpl_sync.sv
module bpl_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/bpl_evt_fifo.sv
module bpl_evt_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s f_d, f_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (f_q.cnt == CAP);
    assign empty   = (f_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.wr_ptr = (f_q.wr_ptr == LAST) ? '0 : f_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            f_d.rd_ptr = (f_q.rd_ptr == LAST) ? '0 : f_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[f_q.wr_ptr] <= din;
        end
    end

    assign head  = mem_q[f_q.rd_ptr];
    assign count = f_q.cnt;

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CAP);

endmodule

// File: rtl/bpl_amod_decode.sv
module bpl_amod_decode
    import bpl_slave_pkg::*;
#(
    parameter int WIN_BITS = 8
) (
    input  logic [5:0]       amod,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] base,
    output xfer_e            kind,
    output logic             sel
);

    localparam logic [BUS_W-1:0] LOW_MASK = (BUS_W'(1) << WIN_BITS) - 1'b1;
    localparam logic [BUS_W-1:0] M16 = BUS_W'(32'h0000_FFFF) & ~LOW_MASK;
    localparam logic [BUS_W-1:0] M24 = BUS_W'(32'h00FF_FFFF) & ~LOW_MASK;
    localparam logic [BUS_W-1:0] M32 = ~LOW_MASK;

    logic [BUS_W-1:0] mask;

    always_comb begin
        case (amod)
            6'h39:   begin kind = XF_SINGLE; mask = M24; end
            6'h3B:   begin kind = XF_BLOCK;  mask = M24; end
            6'h29:   begin kind = XF_SINGLE; mask = M16; end
            6'h09:   begin kind = XF_SINGLE; mask = M32; end
            6'h0B:   begin kind = XF_BLOCK;  mask = M32; end
            6'h08:   begin kind = XF_MBLT;   mask = M32; end
            default: begin kind = XF_NONE;   mask = M32; end
        endcase
        sel = (((addr ^ base) & mask) == '0);
    end

endmodule

// File: rtl/bpl_slave_if.sv
module bpl_slave_if
    import bpl_slave_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_WORDS  = 256,
    parameter int WIN_BITS   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_base,
    input  logic        bus_as_n,
    input  logic [1:0]  bus_ds_n,
    input  logic        bus_wr_n,
    input  logic [5:0]  bus_amod,
    input  logic [31:0] bus_addr,
    output logic        bus_ack_n,
    output logic        bus_err_n,
    output logic        data_oe,
    output logic [31:0] beat_hi,
    output logic [31:0] beat_lo,
    input  logic        evt_push,
    input  logic [31:0] evt_word,
    output logic        evt_full
);

    localparam int WCW = $clog2(MAX_WORDS+1);
    localparam int FCW = $clog2(FIFO_DEPTH+1);
    localparam logic [WCW-1:0] W_CAP  = WCW'(MAX_WORDS);
    localparam logic [WCW-1:0] W_PAIR = WCW'(MAX_WORDS-1);

    typedef struct packed {
        st_e              st;
        xfer_e            kind;
        logic             wr;
        logic [WCW-1:0]   words;
        logic [31:0]      hi;
        logic [31:0]      lo;
    } ctl_s;

    ctl_s c_d, c_q;

    // Synchronized protocol lines: {wr, ds[1:0], as}
    logic [3:0] sync_out;
    logic       as_s;
    logic [1:0] ds_s;
    logic       wr_s;

    bpl_sync #(.W(4), .STAGES(2), .RST_VAL(4'hF)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_wr_n, bus_ds_n, bus_as_n}),
        .dout (sync_out)
    );

    assign as_s = sync_out[0];
    assign ds_s = sync_out[2:1];
    assign wr_s = sync_out[3];

    xfer_e dec_kind;
    logic  dec_sel;

    bpl_amod_decode #(.WIN_BITS(WIN_BITS)) dec_i (
        .amod(bus_amod),
        .addr(bus_addr),
        .base(cfg_base),
        .kind(dec_kind),
        .sel (dec_sel)
    );

    logic           f_pop;
    logic [31:0]    f_head;
    logic [FCW-1:0] f_count;
    logic           f_full;
    logic           f_empty;

    bpl_evt_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk  (clk),
        .rst_n(rst_n),
        .push (evt_push),
        .din  (evt_word),
        .pop  (f_pop),
        .head (f_head),
        .count(f_count),
        .full (f_full),
        .empty(f_empty)
    );

    logic ds_any;
    logic ds_idle;
    logic short_fifo;
    logic over_cap;

    assign ds_any  = (ds_s != 2'b11);
    assign ds_idle = (ds_s == 2'b11);

    always_comb begin
        if (c_q.kind == XF_MBLT) begin
            short_fifo = (f_count < FCW'(2));
            over_cap   = (c_q.words >= W_PAIR);
        end else begin
            short_fifo = f_empty;
            over_cap   = (c_q.words >= W_CAP);
        end
    end

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE: begin
                if (!as_s) begin
                    c_d.kind  = dec_kind;
                    c_d.wr    = !wr_s;
                    c_d.words = '0;
                    c_d.hi    = '0;
                    c_d.st    = dec_sel ? ST_SEL : ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (as_s) c_d.st = ST_IDLE;
            end
            ST_SEL: begin
                if (as_s) begin
                    c_d.st = ST_IDLE;
                end else if (ds_any) begin
                    if (c_q.kind == XF_NONE || c_q.wr) begin
                        c_d.st = ST_ERR;
                    end else if (c_q.kind == XF_SINGLE && c_q.words != '0) begin
                        c_d.st = ST_ERR;
                    end else if (over_cap || short_fifo) begin
                        c_d.st = ST_ERR;
                    end else begin
                        c_d.st = ST_POPA;
                    end
                end
            end
            ST_POPA: begin
                c_d.words = c_q.words + 1'b1;
                if (c_q.kind == XF_MBLT) begin
                    c_d.hi = f_head;
                    c_d.st = ST_POPB;
                end else begin
                    c_d.hi = '0;
                    c_d.lo = f_head;
                    c_d.st = ST_HOLD;
                end
            end
            ST_POPB: begin
                c_d.words = c_q.words + 1'b1;
                c_d.lo    = f_head;
                c_d.st    = ST_HOLD;
            end
            ST_HOLD: begin
                c_d.st = ST_ACK;
            end
            ST_ACK: begin
                if (ds_idle) c_d.st = ST_SEL;
            end
            ST_ERR: begin
                if (ds_idle) c_d.st = ST_SEL;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, kind: XF_NONE, wr: 1'b0, words: '0, hi: '0, lo: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign f_pop     = (c_q.st == ST_POPA) || (c_q.st == ST_POPB);
    assign bus_ack_n = (c_q.st != ST_ACK);
    assign bus_err_n = (c_q.st != ST_ERR);
    assign data_oe   = (c_q.st == ST_HOLD) || (c_q.st == ST_ACK);
    assign beat_hi   = c_q.hi;
    assign beat_lo   = c_q.lo;
    assign evt_full  = f_full;

    // R5
    ack_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_n) |-> ($past(data_oe) && $stable(beat_lo)));

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack_n && ds_any) |=> !bus_ack_n);

    // R8
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.kind == XF_SINGLE) |-> (c_q.words <= WCW'(1)));

    // R9
    word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.words <= W_CAP);

    // R10
    mblt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_HOLD && c_q.kind == XF_MBLT) |-> (c_q.words[0] == 1'b0));

endmodule

// File: tb/bpl_slave_if_tb.sv
module bpl_slave_if_tb_top;

    localparam int DEPTH = 16;
    localparam int MAXW  = 256;
    localparam logic [31:0] BASE = 32'h12AB_CD00;
    localparam int NVEC = 12;
    localparam int R_NONE = 0;
    localparam int R_ACK  = 1;
    localparam int R_ERR  = 2;

    // {amod[5:0], addr[31:0], write, expected reply[1:0]}
    localparam logic [40:0] VEC [NVEC] = '{
        {6'h39, 32'h00AB_CD10, 1'b0, 2'd1},
        {6'h3B, 32'h00AB_CD44, 1'b0, 2'd1},
        {6'h29, 32'h0000_CD00, 1'b0, 2'd1},
        {6'h09, 32'h12AB_CD7C, 1'b0, 2'd1},
        {6'h0B, 32'h12AB_CDFC, 1'b0, 2'd1},
        {6'h08, 32'h12AB_CD00, 1'b0, 2'd1},
        {6'h39, 32'h00AB_CE10, 1'b0, 2'd0},
        {6'h09, 32'h13AB_CD00, 1'b0, 2'd0},
        {6'h29, 32'h0000_CC00, 1'b0, 2'd0},
        {6'h3D, 32'h12AB_CD00, 1'b0, 2'd2},
        {6'h3D, 32'h0000_0000, 1'b0, 2'd0},
        {6'h39, 32'h00AB_CD00, 1'b1, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_as_n = 1'b1;
    logic [1:0]  bus_ds_n = 2'b11;
    logic        bus_wr_n = 1'b1;
    logic [5:0]  bus_amod = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_ack_n, bus_err_n, data_oe, evt_full;
    logic [31:0] beat_hi, beat_lo;
    logic        evt_push = 1'b0;
    logic [31:0] evt_word = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] model [1024];
    int m_wr = 0;
    int m_rd = 0;
    int next_word = 0;

    always #4 clk = ~clk;

    bpl_slave_if #(.FIFO_DEPTH(DEPTH), .MAX_WORDS(MAXW), .WIN_BITS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE),
        .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_wr_n(bus_wr_n),
        .bus_amod(bus_amod), .bus_addr(bus_addr),
        .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n), .data_oe(data_oe),
        .beat_hi(beat_hi), .beat_lo(beat_lo),
        .evt_push(evt_push), .evt_word(evt_word), .evt_full(evt_full)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mpop();
        logic [31:0] w;
        w = model[m_rd % 1024];
        m_rd++;
        return w;
    endfunction

    task automatic push_word();
        logic [31:0] w;
        w = 32'hA000_0000 + 32'(next_word);
        next_word++;
        @(negedge clk);
        evt_push = 1'b1;
        evt_word = w;
        @(negedge clk);
        evt_push = 1'b0;
        if (m_wr - m_rd < DEPTH) begin
            model[m_wr % 1024] = w;
            m_wr++;
        end
    endtask

    task automatic start_cycle(input logic [5:0] am, input logic [31:0] a, input bit wr);
        @(negedge clk);
        bus_amod = am;
        bus_addr = a;
        bus_wr_n = !wr;
        @(negedge clk);
        bus_as_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_cycle();
        @(negedge clk);
        bus_as_n = 1'b1;
        bus_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // One data beat; reports reply, data, whether data was valid and
    // unchanged the clock before the acknowledge, and whether the
    // acknowledge was still low after hold_extra more clocks.
    task automatic beat(output int resp, output logic [31:0] hi, output logic [31:0] lo,
                        output bit pre_ok, output bit still, input int hold_extra);
        logic        p_oe;
        logic [31:0] p_lo;
        resp = R_NONE;
        pre_ok = 1'b0;
        p_oe = 1'b0;
        p_lo = '0;
        @(negedge clk);
        bus_ds_n = 2'b00;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!bus_ack_n) begin resp = R_ACK; pre_ok = p_oe && (p_lo == beat_lo); break; end
            if (!bus_err_n) begin resp = R_ERR; break; end
            p_oe = data_oe;
            p_lo = beat_lo;
        end
        hi = beat_hi;
        lo = beat_lo;
        repeat (hold_extra) @(negedge clk);
        still = !bus_ack_n;
        bus_ds_n = 2'b11;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_ack_n && bus_err_n) break;
        end
    endtask

    initial begin
        int          r;
        logic [31:0] h, l, e1, e2;
        bit          pre, still;

        repeat (3) @(negedge clk);
        // R1: outputs inactive while in reset
        chk(bus_ack_n && bus_err_n && !data_oe && !evt_full, "R1 in reset",
            {bus_ack_n, bus_err_n, data_oe, evt_full}, 4'b1100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_ack_n && bus_err_n && !data_oe && !evt_full, "R1 after reset",
            {bus_ack_n, bus_err_n, data_oe, evt_full}, 4'b1100);

        // R11: overfill, extra pushes dropped
        for (int k = 0; k < 20; k++) push_word();
        chk(evt_full == 1'b1, "R11 full flag", evt_full, 1);

        // Table of single-beat cycles (R2, R3, R4, R7, R10)
        for (int v = 0; v < NVEC; v++) begin
            logic [5:0]  am;
            logic [31:0] ad;
            bit          wr;
            int          ex;
            am = VEC[v][40:35];
            ad = VEC[v][34:3];
            wr = VEC[v][2];
            ex = int'(VEC[v][1:0]);
            start_cycle(am, ad, wr);
            beat(r, h, l, pre, still, 0);
            end_cycle();
            if (ex == R_ACK && am == 6'h08) begin
                e1 = mpop();
                e2 = mpop();
                chk(r == R_ACK && h == e1 && l == e2, "R10 R2 mblt beat", {h, l}, {e1, e2});
            end else if (ex == R_ACK) begin
                e1 = mpop();
                chk(r == R_ACK && l == e1 && h == 0, "R4 R2 read word", {32'(r), l}, {32'(R_ACK), e1});
            end else if (ex == R_NONE) begin
                chk(r == R_NONE, "R3 unselected silent", r, R_NONE);
            end else begin
                chk(r == R_ERR, "R7 bad modifier or write", r, R_ERR);
            end
        end

        // R9 R4 R6: block read drains the FIFO, then errors when empty
        start_cycle(6'h0B, 32'h12AB_CD00, 1'b0);
        while (m_wr - m_rd > 0) begin
            beat(r, h, l, pre, still, 0);
            e1 = mpop();
            chk(r == R_ACK && l == e1, "R9 block beat order", {32'(r), l}, {32'(R_ACK), e1});
        end
        beat(r, h, l, pre, still, 0);
        chk(r == R_ERR, "R6 block beat on empty", r, R_ERR);
        end_cycle();

        // R6: empty single read errors and later data is intact
        start_cycle(6'h39, 32'h00AB_CD00, 1'b0);
        beat(r, h, l, pre, still, 0);
        end_cycle();
        chk(r == R_ERR, "R6 single read on empty", r, R_ERR);

        // R8: second beat in single mode
        push_word();
        push_word();
        start_cycle(6'h39, 32'h00AB_CD00, 1'b0);
        beat(r, h, l, pre, still, 0);
        e1 = mpop();
        chk(r == R_ACK && l == e1, "R8 first single beat", l, e1);
        beat(r, h, l, pre, still, 0);
        chk(r == R_ERR, "R8 second single beat", r, R_ERR);
        end_cycle();

        // R10: one word left, paired beat errors; then succeeds
        start_cycle(6'h08, 32'h12AB_CD00, 1'b0);
        beat(r, h, l, pre, still, 0);
        end_cycle();
        chk(r == R_ERR, "R10 mblt short fifo", r, R_ERR);
        push_word();
        start_cycle(6'h08, 32'h12AB_CD00, 1'b0);
        beat(r, h, l, pre, still, 0);
        end_cycle();
        e1 = mpop();
        e2 = mpop();
        chk(r == R_ACK && h == e1 && l == e2, "R10 mblt pair order", {h, l}, {e1, e2});

        // R9: burst limit
        begin
            int bad = 0;
            start_cycle(6'h3B, 32'h00AB_CD00, 1'b0);
            for (int b = 0; b < MAXW; b++) begin
                push_word();
                beat(r, h, l, pre, still, 0);
                e1 = mpop();
                if (r != R_ACK || l != e1) bad++;
            end
            chk(bad == 0, "R9 256 beats delivered", bad, 0);
            push_word();
            beat(r, h, l, pre, still, 0);
            chk(r == R_ERR, "R9 beat past limit", r, R_ERR);
            end_cycle();
        end

        // R5: data set up before acknowledge, acknowledge held while strobes low
        start_cycle(6'h09, 32'h12AB_CD00, 1'b0);
        beat(r, h, l, pre, still, 6);
        end_cycle();
        e1 = mpop();
        chk(r == R_ACK && l == e1, "R5 read data", l, e1);
        chk(pre, "R5 data valid before ack", pre, 1);
        chk(still, "R5 ack held while strobes low", still, 1);
        chk(bus_ack_n && bus_err_n && !data_oe, "R5 released after strobes",
            {bus_ack_n, bus_err_n, data_oe}, 3'b110);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule